// File: doc/BRIEF.md
# Pipelined Prime Sieve Filter

This block takes a stream of integers greater than one, at most one per clock, and passes on only those that are prime. It is a straight chain of filter cells, each built around one fixed prime divisor chosen at elaboration: the first cell uses 2, the next 3, and so on. A cell that finds a positive value divisible by its prime, where the value is not that prime itself, marks it as composite by flipping its sign. Marked values then travel down the rest of the chain untouched. A final sink cell forwards positive values and discards marked ones.

Each cell adds one register of delay. A valid bit and an end-of-stream marker travel with every value, so gaps in the input reappear as gaps at the output. A composite value is never removed early; it moves through the chain as a marked token and is dropped only at the sink. The end-of-stream marker therefore always comes out, even when its value is composite. Results are exact for inputs below the square of the largest configured divisor.

Top module: `prime_sieve_top`

## Requirements
- R1: While reset is high, and on the first edge after it, `out_valid` and `out_eos` are low.
- R2: A cell marks a positive value that its prime divides, other than the prime itself, by negating it. Any value divisible by one of the configured primes, other than that prime, never appears at the output.
- R3: A positive value that a cell's prime does not divide, or that equals that prime, leaves the cell unchanged. Each configured prime itself appears at the output.
- R4: A cell passes a value that is already negative unchanged, with no division test. A value with several configured prime factors is therefore marked only once and stays dropped.
- R5: The sink emits a value only when it is positive, on `out_data` as an unsigned number. The input run 2,3,...,10 gives the output sequence 2, 3, 5, 7.
- R6: A value accepted with `in_valid` on a clock edge appears `NUM_PRIMES+1` edges later. One value can enter on every edge, and input gaps appear as output gaps. N values therefore drain in N+NUM_PRIMES cycles.
- R7: `out_eos` pulses for one cycle, `NUM_PRIMES+1` edges after `in_valid` and `in_last` were both high. It does so whether or not the value that carried it is emitted.
- R8: Primes larger than the largest configured divisor, but below its square, are emitted. Composites below that bound are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input value present this cycle |
| in_data | input | DATA_W | Unsigned input integer (>1) |
| in_last | input | 1 | Marks the final value of a stream |
| out_valid | output | 1 | A prime is present on out_data |
| out_data | output | DATA_W | Emitted prime |
| out_eos | output | 1 | End of stream reached the output |

## Verification
Every result of this block is due exactly `NUM_PRIMES+1` edges after its input edge: a kept prime, a dropped composite (seen as `out_valid` low), and the end-of-stream pulse. The bench's behavioural model predicts one output slot for each driven cycle and places it in a queue. On every falling edge it compares the three outputs with the slot that is that many cycles old. Bubbles, back-to-back values and composites carrying the end marker are therefore all checked at the single cycle where they are due.

// File: rtl/prime_sieve_pkg.sv
package prime_sieve_pkg;

    // outcome of one cell for the token it holds
    typedef enum logic [1:0] {
        PASS_CLEAN  = 2'd0,
        PASS_MARKED = 2'd1,
        MARK_NOW    = 2'd2
    } cell_action_e;

    // trial-division primality, used only at elaboration
    function automatic bit is_prime_const(input int n);
        bit ok;
        ok = (n >= 2);
        for (int d = 2; d * d <= n; d++) begin
            if (n % d == 0) ok = 1'b0;
        end
        return ok;
    endfunction

    // prime number with zero-based rank idx (0 -> 2, 1 -> 3, ...)
    function automatic int prime_at(input int idx);
        int seen;
        int cand;
        seen = -1;
        cand = 1;
        while (seen < idx) begin
            cand = cand + 1;
            if (is_prime_const(cand)) seen = seen + 1;
        end
        return cand;
    endfunction

endpackage

// File: rtl/sieve_cell.sv
module sieve_cell
    import prime_sieve_pkg::*;
#(
    parameter int SW    = 9,
    parameter int PRIME = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_vld,
    input  logic                 i_eos,
    input  logic signed [SW-1:0] i_val,
    output logic                 o_vld,
    output logic                 o_eos,
    output logic signed [SW-1:0] o_val
);

    localparam logic signed [SW-1:0] DIVISOR = SW'(PRIME);

    cell_action_e        action;
    logic signed [SW-1:0] nxt_val;
    logic signed [SW-1:0] rem;

    always_comb begin
        rem = i_val % DIVISOR;
        if (i_val[SW-1]) begin
            action = PASS_MARKED;
        end else if (i_val != DIVISOR && rem == '0) begin
            action = MARK_NOW;
        end else begin
            action = PASS_CLEAN;
        end
        nxt_val = (action == MARK_NOW) ? -i_val : i_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld <= 1'b0;
            o_eos <= 1'b0;
            o_val <= '0;
        end else begin
            o_vld <= i_vld;
            o_eos <= i_vld & i_eos;
            o_val <= i_vld ? nxt_val : '0;
        end
    end

    // R2: divisible positive non-prime-equal value comes out negated
    a_r2_mark_composite: assert property (@(posedge clk) disable iff (rst)
        (i_vld && !i_val[SW-1] && i_val != DIVISOR && i_val % DIVISOR == '0)
        |=> (o_vld && o_val == -$past(i_val)));

    // R3: non-divisible positive value leaves unchanged
    a_r3_keep_clean: assert property (@(posedge clk) disable iff (rst)
        (i_vld && !i_val[SW-1] && i_val % DIVISOR != '0)
        |=> (o_vld && o_val == $past(i_val)));

    // R4: already marked value is forwarded untouched
    a_r4_marked_passthru: assert property (@(posedge clk) disable iff (rst)
        (i_vld && i_val[SW-1]) |=> (o_vld && o_val == $past(i_val)));

    // R6: valid travels with one cycle of delay
    a_r6_valid_moves: assert property (@(posedge clk) disable iff (rst)
        i_vld |=> o_vld);
    a_r6_bubble_moves: assert property (@(posedge clk) disable iff (rst)
        !i_vld |=> (!o_vld && !o_eos));

endmodule

// File: rtl/sieve_sink.sv
module sieve_sink #(
    parameter int SW = 9,
    parameter int OW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_vld,
    input  logic                 i_eos,
    input  logic signed [SW-1:0] i_val,
    output logic                 out_valid,
    output logic [OW-1:0]        out_data,
    output logic                 out_eos
);

    logic keep;

    always_comb begin
        keep = i_vld && !i_val[SW-1] && (i_val != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_eos   <= 1'b0;
        end else begin
            out_valid <= keep;
            out_data  <= keep ? i_val[OW-1:0] : '0;
            out_eos   <= i_vld & i_eos;
        end
    end

    // R5: marked values never leave
    a_r5_drop_marked: assert property (@(posedge clk) disable iff (rst)
        (i_vld && i_val[SW-1]) |=> !out_valid);

    // R5: positive values leave with their magnitude
    a_r5_emit_positive: assert property (@(posedge clk) disable iff (rst)
        (i_vld && !i_val[SW-1] && i_val != '0)
        |=> (out_valid && out_data == $past(i_val[OW-1:0])));

    // R7: end marker emerges regardless of the value's fate
    a_r7_eos_follows: assert property (@(posedge clk) disable iff (rst)
        (i_vld && i_eos) |=> out_eos);

endmodule

// File: rtl/prime_sieve_top.sv
module prime_sieve_top
    import prime_sieve_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_PRIMES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eos
);

    localparam int SW = DATA_W + 1;

    logic                 vld_c [NUM_PRIMES+1];
    logic                 eos_c [NUM_PRIMES+1];
    logic signed [SW-1:0] val_c [NUM_PRIMES+1];

    assign vld_c[0] = in_valid;
    assign eos_c[0] = in_last;
    assign val_c[0] = $signed({1'b0, in_data});

    for (genvar g = 0; g < NUM_PRIMES; g++) begin : g_cell
        sieve_cell #(
            .SW   (SW),
            .PRIME(prime_at(g))
        ) i_cell (
            .clk  (clk),
            .rst  (rst),
            .i_vld(vld_c[g]),
            .i_eos(eos_c[g]),
            .i_val(val_c[g]),
            .o_vld(vld_c[g+1]),
            .o_eos(eos_c[g+1]),
            .o_val(val_c[g+1])
        );
    end

    sieve_sink #(
        .SW(SW),
        .OW(DATA_W)
    ) i_sink (
        .clk      (clk),
        .rst      (rst),
        .i_vld    (vld_c[NUM_PRIMES]),
        .i_eos    (eos_c[NUM_PRIMES]),
        .i_val    (val_c[NUM_PRIMES]),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_eos  (out_eos)
    );

    // R1: outputs idle on the edge after a reset cycle
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_eos));

endmodule

// File: tb/test_prime_sieve_top.sv
`timescale 1ns/1ps
module test_prime_sieve_top;

    localparam int DATA_W     = 8;
    localparam int NUM_PRIMES = 6;
    localparam int LAT        = NUM_PRIMES + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_eos;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    qv[$];
    int    qd[$];
    int    qe[$];
    string qt[$];

    always #4 clk = ~clk;

    prime_sieve_top #(.DATA_W(DATA_W), .NUM_PRIMES(NUM_PRIMES)) i_prime_sieve_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
        .out_eos(out_eos)
    );

    function automatic bit ref_prime(input int n);
        if (n < 2) return 0;
        for (int d = 2; d < n; d++) if (n % d == 0) return 0;
        return 1;
    endfunction

    // one cycle: check the slot due now, then drive and predict
    task automatic step(input bit v, input int d, input bit l, input string tag);
        @(negedge clk);
        if (qv.size() == LAT) begin
            int ev, ed, ee;
            string et;
            ev = qv.pop_front(); ed = qd.pop_front();
            ee = qe.pop_front(); et = qt.pop_front();
            checks++;
            if (out_valid !== ev[0] || (ev != 0 && out_data !== ed[DATA_W-1:0])
                || out_eos !== ee[0]) begin
                errors++;
                $display("FAIL %s: got v=%0b d=%0d eos=%0b, expected v=%0d d=%0d eos=%0d",
                         et, out_valid, out_data, out_eos, ev, ed, ee);
            end
        end
        in_valid = v;
        in_data  = d[DATA_W-1:0];
        in_last  = l;
        qv.push_back((v && ref_prime(d)) ? 1 : 0);
        qd.push_back(d);
        qe.push_back((v && l) ? 1 : 0);
        qt.push_back(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_eos !== 1'b0) begin
            errors++;
            $display("FAIL R1: got v=%0b eos=%0b, expected v=0 eos=0", out_valid, out_eos);
        end
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < LAT; k++) begin
            qv.push_back(0); qd.push_back(0); qe.push_back(0); qt.push_back("R1");
        end

        // R5: 2..10 gives 2,3,5,7; R7 end marker on composite 10
        for (int n = 2; n <= 10; n++) step(1, n, n == 10, "R5");
        // R6: bubbles between values
        step(1, 11, 0, "R6"); step(0, 0, 0, "R6"); step(1, 13, 0, "R6");
        step(0, 0, 0, "R6"); step(0, 0, 0, "R6"); step(1, 17, 1, "R7");
        step(0, 0, 0, "R6");
        // R2: squares and products of configured primes
        step(1, 4, 0, "R2"); step(1, 9, 0, "R2"); step(1, 25, 0, "R2");
        step(1, 49, 0, "R2"); step(1, 121, 0, "R2"); step(1, 143, 1, "R2");
        // R4: several configured factors, marked once only
        step(1, 30, 0, "R4"); step(1, 210, 0, "R4"); step(1, 60, 0, "R4");
        step(1, 105, 0, "R4"); step(1, 6, 0, "R4"); step(1, 78, 0, "R4");
        // R3: each configured prime passes
        step(1, 2, 0, "R3"); step(1, 3, 0, "R3"); step(1, 5, 0, "R3");
        step(1, 7, 0, "R3"); step(1, 11, 0, "R3"); step(1, 13, 0, "R3");
        // R8: full sweep below 13*13, back to back
        for (int n = 14; n <= 168; n++) step(1, n, n == 168, "R8");
        for (int k = 0; k < LAT + 2; k++) step(0, 0, 0, "R6");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule